// File: doc/BRIEF.md
# Simultaneous-Sample ADC Conversion Sequencer

This block sequences a four-channel sample-and-hold front end that feeds one shared successive-approximation converter. A rising edge on the start input puts every channel into hold at the same moment. The block then converts the enabled channels one at a time, in fixed time slots. At the end of each slot it captures the converter result bus into that channel's own result register. When the last slot of the group ends, it can raise an interrupt.

Channels V and W are always part of a group. Two enable bits add channel U and the auxiliary channel. After each group, the hold output drops so the front end can track the inputs again. A new group cannot begin until a full reacquisition window has passed. A start request that arrives too early is remembered and serviced as soon as the window closes. A host reads the status word to learn that the converter raised the interrupt, and that read clears it. The interrupt line pulses for one clock in edge mode, or stays asserted until the status read in level mode.

Top module: `adc_group_seq`

## Requirements
- R1: After reset, hold_o is 0, every result register and status_o read 0, and irq_no is 1. The first reacquisition window of 20 clocks starts at reset release, so a start given right after release makes hold_o rise only after the 20th clock edge.
- R2: A group starts on a 0-to-1 transition of start_i. From the idle state, hold_o is 1 in the cycle after the one in which start_i went high. Holding start_i high starts only one group.
- R3: Channels are converted in the order V, W, U, AUX, and disabled channels are skipped. conv_strobe_o bit 0 marks V, bit 1 marks W, bit 2 marks U and bit 3 marks AUX. The strobe is one-hot during the first cycle of each slot. V and W are always converted, en_u_i adds U and en_aux_i adds AUX. hold_o stays high for exactly 40·n cycles for n channels.
- R4: At the end of its slot, a channel's register loads {adc_data_i, 1'b0}: an 11-bit two's-complement value left-justified into 12 bits with bit 0 zero. The registers of channels outside the group keep their values.
- R5: After a group ends, hold_o stays low for at least 20 cycles. A start that arrives during a group or during that window is delayed rather than lost. Its group begins so that hold_o is low for exactly 20 cycles in between.
- R6: Any number of start edges during one busy period produce only one extra group.
- R7: With irq_en_i high, the end of a group sets status_o bit 0 (converter source) and bit 11 (global pending) from the next cycle on. With irq_en_i low, status_o stays 0 and irq_no stays 1.
- R8: In a cycle with stat_rd_i high, status_o still shows its current value, and both bits read 0 from the next cycle on. If a group ends in that same cycle, the new event wins and both bits read 1.
- R9: With irq_level_i low (edge mode), irq_no is low for exactly one cycle, the cycle after the group ends.
- R10: With irq_level_i high (level mode), irq_no goes low when status is set and stays low until the cycle after a status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion start request, rising edge |
| en_u_i | input | 1 | Add channel U to the group |
| en_aux_i | input | 1 | Add channel AUX to the group |
| irq_en_i | input | 1 | Enable the completion interrupt |
| irq_level_i | input | 1 | 1 = level interrupt, 0 = one-cycle pulse |
| stat_rd_i | input | 1 | Status read strobe, clears status |
| adc_data_i | input | 11 | Converter result, valid at slot end |
| hold_o | output | 1 | 1 = all channels held, 0 = tracking |
| conv_strobe_o | output | 4 | One-hot per-channel convert strobe |
| status_o | output | 12 | Bit 0 converter source, bit 11 pending |
| result_v_o | output | 12 | Channel V result |
| result_w_o | output | 12 | Channel W result |
| result_u_o | output | 12 | Channel U result |
| result_aux_o | output | 12 | Channel AUX result |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
The end of a group and a host status read can fall in the same clock cycle. Done carelessly, the read's clear would erase a completion that was never seen. The bench provokes this by raising stat_rd_i exactly in the last cycle that hold_o is high. It judges the result by checking that status_o still shows both bits set afterwards and that irq_no remains low in level mode. It separately checks that a lone read clears both bits. The same bench injects start edges in the middle of a group and counts the low cycles of hold_o before the delayed group.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
  localparam int unsigned NCH = 4;
  localparam int unsigned CH_W = 2;
  localparam int unsigned CH_V = 0;
  localparam int unsigned CH_W_IDX = 1;
  localparam int unsigned CH_U = 2;
  localparam int unsigned CH_AUX = 3;

  typedef enum logic [1:0] {ST_ACQ, ST_IDLE, ST_CONV} seq_st_e;

  // {valid, index} of the first enabled channel above cur
  function automatic logic [CH_W:0] next_ch(input logic [CH_W-1:0] cur,
                                            input logic [NCH-1:0] mask);
    logic [CH_W:0] r;
    r = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask[i] && (i > int'(cur))) r = {1'b1, CH_W'(i)};
    end
    return r;
  endfunction
endpackage

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int unsigned ACQ_CYC  = 20,
  parameter int unsigned CONV_CYC = 40
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic           en_u_i,
  input  logic           en_aux_i,
  output logic           hold_o,
  output logic [NCH-1:0] strobe_o,
  output logic [NCH-1:0] cap_o,
  output logic           done_o
);
  localparam int unsigned MAXC = (ACQ_CYC > CONV_CYC) ? ACQ_CYC : CONV_CYC;
  localparam int unsigned CNT_W = $clog2(MAXC);
  localparam logic [CNT_W-1:0] ACQ_LAST = CNT_W'(ACQ_CYC - 1);
  localparam logic [CNT_W-1:0] CONV_LAST = CNT_W'(CONV_CYC - 1);

  seq_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CH_W-1:0] ch_q, ch_d;
  logic [NCH-1:0]  mask_q, mask_d;
  logic            start_q, pend_q, pend_d;
  logic            rise, req, go, acq_end, slot_end;
  logic [CH_W:0]   nxt;

  assign rise     = start_i & ~start_q;
  assign req      = rise | pend_q;
  assign acq_end  = (st_q == ST_ACQ) && (cnt_q == ACQ_LAST);
  assign slot_end = (st_q == ST_CONV) && (cnt_q == CONV_LAST);
  assign go       = req && ((st_q == ST_IDLE) || acq_end);
  assign nxt      = next_ch(ch_q, mask_q);
  assign pend_d   = (pend_q | rise) & ~go;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ch_d   = ch_q;
    mask_d = mask_q;
    unique case (st_q)
      ST_ACQ: begin
        if (acq_end) begin
          cnt_d = '0;
          st_d  = req ? ST_CONV : ST_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_IDLE: if (req) st_d = ST_CONV;
      ST_CONV: begin
        if (slot_end) begin
          cnt_d = '0;
          if (nxt[CH_W]) ch_d = nxt[CH_W-1:0];
          else           st_d = ST_ACQ;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = ST_ACQ;
    endcase
    if (go) begin
      cnt_d  = '0;
      ch_d   = '0;
      mask_d = {en_aux_i, en_u_i, 2'b11};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_ACQ;
      cnt_q   <= '0;
      ch_q    <= '0;
      mask_q  <= '0;
      start_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      ch_q    <= ch_d;
      mask_q  <= mask_d;
      start_q <= start_i;
      pend_q  <= pend_d;
    end
  end

  assign hold_o = (st_q == ST_CONV);
  assign done_o = slot_end && !nxt[CH_W];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign strobe_o[i] = hold_o && (cnt_q == '0) && (ch_q == CH_W'(i));
    assign cap_o[i]    = slot_end && (ch_q == CH_W'(i));
  end

  p_strobe_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));

  p_strobe_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_o != '0) |-> hold_o);

  p_hold_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> (($past(st_q) == ST_IDLE) || ($past(cnt_q) == ACQ_LAST)));

  p_done_in_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !hold_o);
endmodule

// File: rtl/adcseq_results.sv
module adcseq_results
  import adcseq_pkg::*;
#(
  parameter int unsigned RES_W = 11,
  parameter int unsigned REG_W = 12
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NCH-1:0]            cap_i,
  input  logic [RES_W-1:0]          data_i,
  output logic [NCH-1:0][REG_W-1:0] res_o
);
  localparam int unsigned PAD = REG_W - RES_W;

  for (genvar i = 0; i < NCH; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       res_o[i] <= '0;
      else if (cap_i[i]) res_o[i] <= {data_i, {PAD{1'b0}}};
    end

    p_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cap_i[i] |=> $stable(res_o[i]));
  end
endmodule

// File: rtl/adcseq_irq.sv
module adcseq_irq #(
  parameter int unsigned STAT_W   = 12,
  parameter int unsigned SRC_BIT  = 0,
  parameter int unsigned PEND_BIT = STAT_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic              irq_en_i,
  input  logic              irq_level_i,
  input  logic              stat_rd_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_no
);
  logic src_q, pend_q, pulse_q, set;

  assign set = done_i & irq_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= 1'b0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= set;
      if (set) begin
        src_q  <= 1'b1;
        pend_q <= 1'b1;
      end else if (stat_rd_i) begin
        src_q  <= 1'b0;
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[SRC_BIT]  = src_q;
    status_o[PEND_BIT] = pend_q;
  end

  assign irq_no = ~(irq_level_i ? pend_q : pulse_q);

  p_rd_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !set) |=> (status_o == '0));

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set |=> (status_o[SRC_BIT] && status_o[PEND_BIT]));

  p_edge_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_level_i && !irq_no) |=> (irq_no || irq_level_i));

  p_level_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_level_i && !irq_no && !stat_rd_i) |=> (!irq_no || !irq_level_i));
endmodule

// File: rtl/adc_group_seq.sv
module adc_group_seq
  import adcseq_pkg::*;
#(
  parameter int unsigned ACQ_CYC  = 20,
  parameter int unsigned CONV_CYC = 40,
  parameter int unsigned RES_W    = 11,
  parameter int unsigned REG_W    = 12,
  parameter int unsigned STAT_W   = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              en_u_i,
  input  logic              en_aux_i,
  input  logic              irq_en_i,
  input  logic              irq_level_i,
  input  logic              stat_rd_i,
  input  logic [RES_W-1:0]  adc_data_i,
  output logic              hold_o,
  output logic [NCH-1:0]    conv_strobe_o,
  output logic [STAT_W-1:0] status_o,
  output logic [REG_W-1:0]  result_v_o,
  output logic [REG_W-1:0]  result_w_o,
  output logic [REG_W-1:0]  result_u_o,
  output logic [REG_W-1:0]  result_aux_o,
  output logic              irq_no
);
  logic [NCH-1:0]            cap;
  logic                      done;
  logic [NCH-1:0][REG_W-1:0] res;

  adcseq_ctrl #(.ACQ_CYC(ACQ_CYC), .CONV_CYC(CONV_CYC)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .en_u_i   (en_u_i),
    .en_aux_i (en_aux_i),
    .hold_o   (hold_o),
    .strobe_o (conv_strobe_o),
    .cap_o    (cap),
    .done_o   (done)
  );

  adcseq_results #(.RES_W(RES_W), .REG_W(REG_W)) u_res (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_i  (cap),
    .data_i (adc_data_i),
    .res_o  (res)
  );

  adcseq_irq #(.STAT_W(STAT_W)) u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .done_i      (done),
    .irq_en_i    (irq_en_i),
    .irq_level_i (irq_level_i),
    .stat_rd_i   (stat_rd_i),
    .status_o    (status_o),
    .irq_no      (irq_no)
  );

  assign result_v_o   = res[CH_V];
  assign result_w_o   = res[CH_W_IDX];
  assign result_u_o   = res[CH_U];
  assign result_aux_o = res[CH_AUX];
endmodule

// File: tb/adc_group_seq_test.sv
module adc_group_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, en_u_i = 1'b0, en_aux_i = 1'b0;
  logic        irq_en_i = 1'b0, irq_level_i = 1'b0, stat_rd_i = 1'b0;
  logic [10:0] adc_data_i = '0;
  logic        hold_o, irq_no;
  logic [3:0]  conv_strobe_o;
  logic [11:0] status_o, result_v_o, result_w_o, result_u_o, result_aux_o;

  int errors = 0;
  int checks = 0;
  logic [10:0] dval [4];

  always #5 clk_i = ~clk_i;

  adc_group_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .en_u_i(en_u_i),
    .en_aux_i(en_aux_i), .irq_en_i(irq_en_i), .irq_level_i(irq_level_i),
    .stat_rd_i(stat_rd_i), .adc_data_i(adc_data_i), .hold_o(hold_o),
    .conv_strobe_o(conv_strobe_o), .status_o(status_o),
    .result_v_o(result_v_o), .result_w_o(result_w_o), .result_u_o(result_u_o),
    .result_aux_o(result_aux_o), .irq_no(irq_no)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic pulse_start();
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic clear_status();
    stat_rd_i = 1'b1;
    @(negedge clk_i);
    stat_rd_i = 1'b0;
  endtask

  // follows one group: order, data feed, hold length
  task automatic watch_group(input int n, input logic [7:0] ord, input bit rd_end,
                             input bit inj, input string req);
    int cnt = 0;
    int k = 0;
    int to = 0;
    while (!hold_o && to < 400) begin
      to++;
      @(negedge clk_i);
    end
    while (hold_o) begin
      if (conv_strobe_o != '0) begin
        int idx = 0;
        for (int i = 0; i < 4; i++) if (conv_strobe_o[i]) idx = i;
        if (k < 4) chk({req, " R3 order"}, idx, ord[2*k +: 2]);
        k++;
        adc_data_i = dval[idx];
      end
      cnt++;
      start_i = inj && (cnt == 10 || cnt == 30);
      stat_rd_i = rd_end && (cnt == 40 * n);
      @(negedge clk_i);
    end
    start_i = 1'b0;
    stat_rd_i = 1'b0;
    chk({req, " R3 hold length"}, cnt, 40 * n);
    chk({req, " R3 slot count"}, k, n);
  endtask

  task automatic t_reset();
    chk("R1 hold", hold_o, 0);
    chk("R1 status", status_o, 0);
    chk("R1 irq", irq_no, 1);
    chk("R1 results", {result_v_o, result_w_o, result_u_o, result_aux_o}, 0);
    dval[0] = 11'h001; dval[1] = 11'h002; dval[2] = 11'h0; dval[3] = 11'h0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    tick(18);
    chk("R1 R5 still acquiring", hold_o, 0);
    @(negedge clk_i);
    chk("R1 R5 delayed start", hold_o, 1);
    watch_group(2, 8'h04, 0, 0, "reset");
    chk("R4 v", result_v_o, 12'h002);
    chk("R4 w", result_w_o, 12'h004);
  endtask

  task automatic t_two();
    tick(25);
    dval[0] = 11'h2AA; dval[1] = 11'h155; dval[2] = 11'h111; dval[3] = 11'h222;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 hold next cycle", hold_o, 1);
    watch_group(2, 8'h04, 0, 0, "two");
    chk("R4 v", result_v_o, 12'h554);
    chk("R4 w", result_w_o, 12'h2AA);
    chk("R4 u untouched", result_u_o, 0);
    chk("R4 aux untouched", result_aux_o, 0);
    chk("R7 disabled status", status_o, 0);
    chk("R7 disabled irq", irq_no, 1);
  endtask

  task automatic t_four_edge();
    tick(25);
    en_u_i = 1; en_aux_i = 1; irq_en_i = 1; irq_level_i = 0;
    dval[0] = 11'h123; dval[1] = 11'h7FF; dval[2] = 11'h400; dval[3] = 11'h001;
    pulse_start();
    watch_group(4, 8'hE4, 0, 0, "four");
    chk("R9 pulse low", irq_no, 0);
    chk("R7 status set", status_o, 12'h801);
    chk("R4 v", result_v_o, 12'h246);
    chk("R4 w max", result_w_o, 12'hFFE);
    chk("R4 u min", result_u_o, 12'h800);
    chk("R4 aux", result_aux_o, 12'h002);
    @(negedge clk_i);
    chk("R9 pulse one cycle", irq_no, 1);
    stat_rd_i = 1'b1;
    chk("R8 read shows value", status_o, 12'h801);
    @(negedge clk_i);
    stat_rd_i = 1'b0;
    chk("R8 read clears", status_o, 0);
  endtask

  task automatic t_partial();
    tick(25);
    irq_en_i = 0; en_u_i = 1; en_aux_i = 0;
    dval[0] = 11'h010; dval[1] = 11'h020; dval[2] = 11'h030; dval[3] = 11'h040;
    pulse_start();
    watch_group(3, 8'h24, 0, 0, "u only");
    chk("R4 u", result_u_o, 12'h060);
    chk("R4 aux kept", result_aux_o, 12'h002);
    tick(25);
    en_u_i = 0; en_aux_i = 1;
    dval[2] = 11'h050; dval[3] = 11'h3FF;
    pulse_start();
    watch_group(3, 8'h34, 0, 0, "aux only");
    chk("R4 aux", result_aux_o, 12'h7FE);
    chk("R4 u kept", result_u_o, 12'h060);
    en_aux_i = 0;
  endtask

  task automatic t_back_to_back();
    int gap = 0;
    int rises = 0;
    logic prev;
    tick(25);
    pulse_start();
    watch_group(2, 8'h04, 0, 1, "busy start");
    while (!hold_o && gap < 100) begin
      gap++;
      @(negedge clk_i);
    end
    chk("R5 reacquire gap", gap, 20);
    watch_group(2, 8'h04, 0, 0, "delayed group");
    prev = hold_o;
    for (int i = 0; i < 120; i++) begin
      @(negedge clk_i);
      if (hold_o && !prev) rises++;
      prev = hold_o;
    end
    chk("R6 single pending", rises, 0);
  endtask

  task automatic t_held_start();
    int rises = 0;
    logic prev;
    tick(25);
    prev = hold_o;
    start_i = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      if (hold_o && !prev) rises++;
      prev = hold_o;
    end
    start_i = 1'b0;
    chk("R2 held start one group", rises, 1);
  endtask

  task automatic t_level();
    int high = 0;
    tick(25);
    irq_en_i = 1; irq_level_i = 1;
    pulse_start();
    watch_group(2, 8'h04, 0, 0, "level");
    for (int i = 0; i < 30; i++) begin
      if (irq_no) high++;
      @(negedge clk_i);
    end
    chk("R10 stays low", high, 0);
    chk("R7 status", status_o, 12'h801);
    clear_status();
    chk("R10 released by read", irq_no, 1);
    chk("R8 cleared", status_o, 0);
  endtask

  task automatic t_collide();
    tick(25);
    pulse_start();
    watch_group(2, 8'h04, 1, 0, "collide");
    chk("R8 set wins over read", status_o, 12'h801);
    chk("R10 irq held", irq_no, 0);
    clear_status();
    chk("R8 later read clears", status_o, 0);
    chk("R10 irq released", irq_no, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    t_reset();
    t_two();
    t_four_edge();
    t_partial();
    t_back_to_back();
    t_held_start();
    t_level();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule